// File: doc/BRIEF.md
# CD Decoder Host Register Port

This block is the host-facing register file of a CD data decoder. A host reaches it through a byte-wide port. A 4-bit pointer selects which register the next access touches. Reads and writes see two different maps of sixteen registers each. After most accesses the pointer moves on by one, so a host can stream through a group of registers without reloading it. The host can also load the pointer directly at any time.

The registers hold several kinds of state:
- the interface control and status bytes;
- a 16-bit byte counter, a 16-bit data address, a 16-bit block pointer and a 16-bit write address;
- three control bytes and a sub-output byte;
- header bytes and status bytes, which are read-only.

Some accesses also act as strobes: a transfer trigger, a transfer acknowledge and a soft reset.

The block keeps a record of which decoder status registers the host has read. When the host reads the last status byte, that record decides whether the decode-ready value is loaded into that byte for the next read. Two event inputs stand in for the decoder core: `end_evt` raises the active-low end-of-transfer flag and `dec_evt` raises the active-low decode flag. Host accesses use a one-cycle read strobe or write strobe. Read data is registered and valid from the cycle after the read strobe.

Top module: `dec_reg_port`

## Requirements
- R1: Synchronous reset (`rst`) sets the pointer to 0 and clears `busy`, `xfer_start`, `if_ctrl`, `sub_out`, `data_addr` and `ctrl_out`. After reset, reads return these values:
  - read register 1 (interface status) = 0xFF;
  - registers 2–3 (byte counter) = 0; registers 8–9 (block pointer) = 0;
  - registers 10–11 (write address) = 0x60, 0x12, which is 4704;
  - header registers 4–7 = 00, 00, 00, 01;
  - status registers 12–15 = 80, 00, 00, 00.
- R2: A read strobe at pointer N loads `rdata` with register N at the clock edge. If N < 15 the pointer becomes N+1; at N = 15 it stays.
- R3: A write strobe advances the pointer by one at pointers 0–5 and 8–13. At pointers 6, 7, 14 and 15 the pointer stays where it is.
- R4: The write map places bytes as follows, low byte first in each pair:
  - 0: `sub_out`;
  - 2–3: byte counter; 4–5: `data_addr`; 8–9: write address; 12–13: block pointer;
  - 10, 11 and 14: control bytes 0, 1 and 2, which appear on `ctrl_out[7:0]`, `[15:8]` and `[23:16]`.
  The byte counter, block pointer and write address read back at read registers 2–3, 8–9 and 10–11.
- R5: A write to register 1 loads `if_ctrl`. If bit 1 of the written byte is 0, the same write zeroes the byte counter, clears `busy` and sets interface status bit 3.
- R6: A write to register 6 while `if_ctrl` bit 1 is set clears interface status bit 3 and sets `busy`. It also raises `xfer_start` for exactly the next cycle. With `if_ctrl` bit 1 clear, the same write changes nothing.
- R7: A write to register 7 sets interface status bit 6. `end_evt` clears that bit.
- R8: Reading register 15 returns the old status byte 3 and sets interface status bit 5; `dec_evt` clears that bit. Status byte 3 becomes 0x80 at that read only if all three of these hold:
  - control byte 0 bit 7 is set;
  - `if_ctrl` bit 5 is set;
  - every read register in {1, 4, 5, 6, 7, 8, 9, 12, 13, 14} has been read since the last reset.
- R9: A write to register 15 restores every R1 register value and clears the read record at the same clock edge. The pointer stays at 15.
- R10: `ptr_we` loads the pointer from `ptr_wdata` and takes precedence over any automatic advance. An access strobed in the same cycle still uses the old pointer.
- R11: When both strobes are asserted together, the write is performed and the read is ignored: `rdata` holds its value.
- R12: Read register 0 returns `cmd_in` as sampled at the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_we | input | 1 | Direct pointer load strobe |
| ptr_wdata | input | 4 | Pointer load value |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| wdata | input | 8 | Write data |
| cmd_in | input | 8 | Command input byte (read register 0) |
| end_evt | input | 1 | Transfer-end event, clears interface status bit 6 |
| dec_evt | input | 1 | Decode event, clears interface status bit 5 |
| rdata | output | 8 | Registered read data |
| ptr | output | 4 | Current register pointer |
| if_ctrl | output | 8 | Interface control byte |
| sub_out | output | 8 | Sub-output byte |
| data_addr | output | 16 | Data address counter |
| ctrl_out | output | 24 | Control bytes 2,1,0 |
| busy | output | 1 | Transfer in progress |
| xfer_start | output | 1 | One-cycle transfer start pulse |

## Verification
A wrong pointer shows up on the very next access. Data lands in, or comes from, a neighbouring register, and `ptr` itself differs one cycle after the strobe. A corrupted status, counter or control bit is invisible until the host reads that register or looks at the exported outputs. The bench therefore reads registers back right after every side effect. A fault in the read record is the slowest to surface: it shows only when register 15 is read twice with the decode enables set. The bench walks that sequence with one tracked register left unread and then with all of them read.

// File: rtl/dec_reg_pkg.sv
package dec_reg_pkg;

    localparam int unsigned PTR_W  = 4;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned NREG   = 1 << PTR_W;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [2*DATA_W-1:0] word_t;

    typedef enum logic [PTR_W-1:0] {
        RD_CMD, RD_IFST, RD_CNT_LO, RD_CNT_HI,
        RD_HDR0, RD_HDR1, RD_HDR2, RD_HDR3,
        RD_BLK_LO, RD_BLK_HI, RD_WA_LO, RD_WA_HI,
        RD_ST0, RD_ST1, RD_ST2, RD_ST3
    } rd_sel_e;

    typedef enum logic [PTR_W-1:0] {
        WR_SUB, WR_IFCTL, WR_CNT_LO, WR_CNT_HI,
        WR_ADR_LO, WR_ADR_HI, WR_TRIG, WR_ACK,
        WR_WA_LO, WR_WA_HI, WR_CTL0, WR_CTL1,
        WR_BLK_LO, WR_BLK_HI, WR_CTL2, WR_SRST
    } wr_sel_e;

    // bit positions with meaning to neighbours
    localparam int unsigned IFST_IDLE   = 3;
    localparam int unsigned IFST_DEC_N  = 5;
    localparam int unsigned IFST_END_N  = 6;
    localparam int unsigned IFCTL_XEN   = 1;
    localparam int unsigned IFCTL_DECEN = 5;
    localparam int unsigned CTL0_DECEN  = 7;

    localparam byte_t             IFST_RST   = 8'hFF;
    localparam logic [4*DATA_W-1:0] HDR_CONST  = 32'h0100_0000; // byte k at [8k+:8]
    localparam logic [4*DATA_W-1:0] STAT_CONST = 32'h0000_0080;
    localparam byte_t             ST3_READY  = 8'h80;

    typedef struct packed {
        logic  rd;
        logic  wr;
        ptr_t  idx;
    } access_t;

    typedef struct packed {
        byte_t ifst;
        byte_t ifctl;
        byte_t sub;
        word_t cnt;
        word_t adr;
        word_t blk;
        word_t wa;
        byte_t ctl0;
        byte_t ctl1;
        byte_t ctl2;
        byte_t st3;
        logic  busy;
    } regs_t;

    function automatic regs_t regs_reset(input word_t wa_rst);
        regs_t r;
        r       = '0;
        r.ifst  = IFST_RST;
        r.wa    = wa_rst;
        r.st3   = STAT_CONST[3*DATA_W +: DATA_W];
        return r;
    endfunction

    function automatic logic rd_advances(input ptr_t i);
        return i != ptr_t'(RD_ST3);
    endfunction

    function automatic logic wr_advances(input ptr_t i);
        return !(i == ptr_t'(WR_TRIG) || i == ptr_t'(WR_ACK) ||
                 i == ptr_t'(WR_CTL2) || i == ptr_t'(WR_SRST));
    endfunction

endpackage

// File: rtl/dec_ptr_ctrl.sv
module dec_ptr_ctrl
    import dec_reg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  ptr_t    load_val,
    input  access_t acc,
    output ptr_t    ptr_q
);

    ptr_t ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (load)
            ptr_d = load_val;
        else if (acc.wr)
            ptr_d = wr_advances(ptr_q) ? ptr_q + ptr_t'(1) : ptr_q;
        else if (acc.rd)
            ptr_d = rd_advances(ptr_q) ? ptr_q + ptr_t'(1) : ptr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

endmodule

// File: rtl/dec_read_track.sv
module dec_read_track
    import dec_reg_pkg::*;
#(
    parameter logic [NREG-1:0] TRACK_MASK = 16'h73F2
)(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic rd_fire,
    input  ptr_t idx,
    output logic all_seen
);

    logic [NREG-1:0] seen;

    for (genvar i = 0; i < int'(NREG); i++) begin : g_bit
        if (TRACK_MASK[i]) begin : g_trk
            always_ff @(posedge clk) begin
                if (rst || clear)
                    seen[i] <= 1'b0;
                else if (rd_fire && idx == ptr_t'(i))
                    seen[i] <= 1'b1;
            end
        end else begin : g_const
            assign seen[i] = 1'b0;
        end
    end

    assign all_seen = &(seen | ~TRACK_MASK);

endmodule

// File: rtl/dec_reg_bank.sv
module dec_reg_bank
    import dec_reg_pkg::*;
#(
    parameter word_t WA_RESET = 16'd4704
)(
    input  logic    clk,
    input  logic    rst,
    input  access_t acc,
    input  byte_t   wdata,
    input  byte_t   cmd_in,
    input  logic    end_evt,
    input  logic    dec_evt,
    input  logic    all_seen,
    output regs_t   regs_q,
    output byte_t   rdata,
    output logic    xfer_start
);

    byte_t rd_mux;

    always_comb begin
        unique case (rd_sel_e'(acc.idx))
            RD_CMD:    rd_mux = cmd_in;
            RD_IFST:   rd_mux = regs_q.ifst;
            RD_CNT_LO: rd_mux = regs_q.cnt[7:0];
            RD_CNT_HI: rd_mux = regs_q.cnt[15:8];
            RD_HDR0:   rd_mux = HDR_CONST[0*DATA_W +: DATA_W];
            RD_HDR1:   rd_mux = HDR_CONST[1*DATA_W +: DATA_W];
            RD_HDR2:   rd_mux = HDR_CONST[2*DATA_W +: DATA_W];
            RD_HDR3:   rd_mux = HDR_CONST[3*DATA_W +: DATA_W];
            RD_BLK_LO: rd_mux = regs_q.blk[7:0];
            RD_BLK_HI: rd_mux = regs_q.blk[15:8];
            RD_WA_LO:  rd_mux = regs_q.wa[7:0];
            RD_WA_HI:  rd_mux = regs_q.wa[15:8];
            RD_ST0:    rd_mux = STAT_CONST[0*DATA_W +: DATA_W];
            RD_ST1:    rd_mux = STAT_CONST[1*DATA_W +: DATA_W];
            RD_ST2:    rd_mux = STAT_CONST[2*DATA_W +: DATA_W];
            default:   rd_mux = regs_q.st3;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q     <= regs_reset(WA_RESET);
            rdata      <= '0;
            xfer_start <= 1'b0;
        end else begin
            xfer_start <= 1'b0;
            if (end_evt) regs_q.ifst[IFST_END_N] <= 1'b0;
            if (dec_evt) regs_q.ifst[IFST_DEC_N] <= 1'b0;
            if (acc.wr) begin
                unique case (wr_sel_e'(acc.idx))
                    WR_SUB:    regs_q.sub <= wdata;
                    WR_IFCTL: begin
                        regs_q.ifctl <= wdata;
                        if (!wdata[IFCTL_XEN]) begin
                            regs_q.cnt             <= '0;
                            regs_q.busy            <= 1'b0;
                            regs_q.ifst[IFST_IDLE] <= 1'b1;
                        end
                    end
                    WR_CNT_LO: regs_q.cnt[7:0]  <= wdata;
                    WR_CNT_HI: regs_q.cnt[15:8] <= wdata;
                    WR_ADR_LO: regs_q.adr[7:0]  <= wdata;
                    WR_ADR_HI: regs_q.adr[15:8] <= wdata;
                    WR_TRIG: begin
                        if (regs_q.ifctl[IFCTL_XEN]) begin
                            regs_q.ifst[IFST_IDLE] <= 1'b0;
                            regs_q.busy            <= 1'b1;
                            xfer_start             <= 1'b1;
                        end
                    end
                    WR_ACK:    regs_q.ifst[IFST_END_N] <= 1'b1;
                    WR_WA_LO:  regs_q.wa[7:0]   <= wdata;
                    WR_WA_HI:  regs_q.wa[15:8]  <= wdata;
                    WR_CTL0:   regs_q.ctl0      <= wdata;
                    WR_CTL1:   regs_q.ctl1      <= wdata;
                    WR_BLK_LO: regs_q.blk[7:0]  <= wdata;
                    WR_BLK_HI: regs_q.blk[15:8] <= wdata;
                    WR_CTL2:   regs_q.ctl2      <= wdata;
                    default:   regs_q           <= regs_reset(WA_RESET);
                endcase
            end else if (acc.rd) begin
                rdata <= rd_mux;
                if (acc.idx == ptr_t'(RD_ST3)) begin
                    regs_q.ifst[IFST_DEC_N] <= 1'b1;
                    if (regs_q.ctl0[CTL0_DECEN] && regs_q.ifctl[IFCTL_DECEN] && all_seen)
                        regs_q.st3 <= ST3_READY;
                end
            end
        end
    end

endmodule

// File: rtl/dec_reg_port.sv
module dec_reg_port
    import dec_reg_pkg::*;
#(
    parameter logic [15:0] WA_RESET   = 16'd4704,
    parameter logic [15:0] TRACK_MASK = 16'h73F2
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        ptr_we,
    input  logic [3:0]  ptr_wdata,
    input  logic        rd_stb,
    input  logic        wr_stb,
    input  logic [7:0]  wdata,
    input  logic [7:0]  cmd_in,
    input  logic        end_evt,
    input  logic        dec_evt,
    output logic [7:0]  rdata,
    output logic [3:0]  ptr,
    output logic [7:0]  if_ctrl,
    output logic [7:0]  sub_out,
    output logic [15:0] data_addr,
    output logic [23:0] ctrl_out,
    output logic        busy,
    output logic        xfer_start
);

    access_t acc;
    regs_t   regs;
    ptr_t    ptr_q;
    logic    all_seen;
    logic    soft_rst;

    assign acc.wr   = wr_stb;
    assign acc.rd   = rd_stb & ~wr_stb;
    assign acc.idx  = ptr_q;
    assign soft_rst = acc.wr && acc.idx == ptr_t'(WR_SRST);

    dec_ptr_ctrl u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_we),
        .load_val (ptr_wdata),
        .acc      (acc),
        .ptr_q    (ptr_q)
    );

    dec_read_track #(.TRACK_MASK(TRACK_MASK)) u_trk (
        .clk      (clk),
        .rst      (rst),
        .clear    (soft_rst),
        .rd_fire  (acc.rd),
        .idx      (ptr_q),
        .all_seen (all_seen)
    );

    dec_reg_bank #(.WA_RESET(WA_RESET)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .wdata      (wdata),
        .cmd_in     (cmd_in),
        .end_evt    (end_evt),
        .dec_evt    (dec_evt),
        .all_seen   (all_seen),
        .regs_q     (regs),
        .rdata      (rdata),
        .xfer_start (xfer_start)
    );

    assign ptr       = ptr_q;
    assign if_ctrl   = regs.ifctl;
    assign sub_out   = regs.sub;
    assign data_addr = regs.adr;
    assign ctrl_out  = {regs.ctl2, regs.ctl1, regs.ctl0};
    assign busy      = regs.busy;

endmodule

// File: rtl/dec_reg_port_chk.sv
module dec_reg_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        ptr_we,
    input logic [3:0]  ptr_wdata,
    input logic        rd_stb,
    input logic        wr_stb,
    input logic [7:0]  wdata,
    input logic [3:0]  ptr,
    input logic [7:0]  if_ctrl,
    input logic [7:0]  sub_out,
    input logic [15:0] data_addr,
    input logic [23:0] ctrl_out,
    input logic        busy,
    input logic        xfer_start
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (ptr == 4'd0 && !busy && !xfer_start && if_ctrl == 8'd0 && sub_out == 8'd0));

    assert_read_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !wr_stb && !ptr_we && ptr != 4'd15) |=> ptr == $past(ptr) + 4'd1);

    assert_read_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !wr_stb && !ptr_we && ptr == 4'd15) |=> $stable(ptr));

    assert_write_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !ptr_we && (ptr == 4'd6 || ptr == 4'd7 || ptr == 4'd14 || ptr == 4'd15))
        |=> $stable(ptr));

    assert_write_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !ptr_we && !(ptr == 4'd6 || ptr == 4'd7 || ptr == 4'd14 || ptr == 4'd15))
        |=> ptr == $past(ptr) + 4'd1);

    assert_stop_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && ptr == 4'd1 && !wdata[1]) |=> (!busy && if_ctrl == $past(wdata)));

    assert_start_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && ptr == 4'd6 && if_ctrl[1]) |=> (busy && xfer_start));

    assert_no_start_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && ptr == 4'd6 && !if_ctrl[1]) |=> (!xfer_start && busy == $past(busy)));

    assert_pulse_busy_R6: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> busy);

    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !ptr_we && ptr == 4'd15)
        |=> (ptr == 4'd15 && !busy && if_ctrl == 8'd0 && sub_out == 8'd0
             && data_addr == 16'd0 && ctrl_out == 24'd0));

    assert_ptr_load_R10: assert property (@(posedge clk) disable iff (rst)
        ptr_we |=> ptr == $past(ptr_wdata));

endmodule

bind dec_reg_port dec_reg_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ptr_we     (ptr_we),
    .ptr_wdata  (ptr_wdata),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .wdata      (wdata),
    .ptr        (ptr),
    .if_ctrl    (if_ctrl),
    .sub_out    (sub_out),
    .data_addr  (data_addr),
    .ctrl_out   (ctrl_out),
    .busy       (busy),
    .xfer_start (xfer_start)
);

// File: tb/sim_dec_reg_port.sv
`timescale 1ns/1ps
module sim_dec_reg_port;

    logic        clk = 1'b0;
    logic        rst;
    logic        ptr_we, rd_stb, wr_stb, end_evt, dec_evt;
    logic [3:0]  ptr_wdata;
    logic [7:0]  wdata, cmd_in, rdata, if_ctrl, sub_out;
    logic [3:0]  ptr;
    logic [15:0] data_addr;
    logic [23:0] ctrl_out;
    logic        busy, xfer_start;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dec_reg_port u0 (
        .clk(clk), .rst(rst), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .cmd_in(cmd_in),
        .end_evt(end_evt), .dec_evt(dec_evt), .rdata(rdata), .ptr(ptr),
        .if_ctrl(if_ctrl), .sub_out(sub_out), .data_addr(data_addr),
        .ctrl_out(ctrl_out), .busy(busy), .xfer_start(xfer_start)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_ptr(input logic [3:0] p);
        @(negedge clk); ptr_we = 1'b1; ptr_wdata = p;
        @(negedge clk); ptr_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_stb = 1'b1; wdata = d;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic rd(output logic [7:0] d);
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
        d = rdata;
    endtask

    task automatic wr_at(input logic [3:0] p, input logic [7:0] d);
        set_ptr(p); wr(d);
    endtask

    task automatic rd_at(input logic [3:0] p, output logic [7:0] d);
        set_ptr(p); rd(d);
    endtask

    task automatic pulse_evt(input bit is_end);
        @(negedge clk); if (is_end) end_evt = 1'b1; else dec_evt = 1'b1;
        @(negedge clk); end_evt = 1'b0; dec_evt = 1'b0;
    endtask

    function automatic logic [7:0] reset_val(input int i);
        case (i)
            0: return 8'h5A;  1: return 8'hFF;  7: return 8'h01;
            10: return 8'h60; 11: return 8'h12; 12: return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    task automatic t_reset;
        logic [7:0] v;
        chk("R1", "ptr", ptr, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "xfer_start", xfer_start, 0);
        chk("R1", "outputs", {if_ctrl, sub_out, data_addr, ctrl_out}, 0);
        cmd_in = 8'h5A;
        for (int i = 0; i < 16; i++) begin
            rd(v);
            chk("R1", $sformatf("read reg %0d", i), v, reset_val(i));
            chk("R2", $sformatf("ptr after read %0d", i), ptr, (i < 15) ? i + 1 : 15);
        end
    endtask

    task automatic t_wr_ptr;
        for (int i = 0; i < 16; i++) begin
            wr_at(i[3:0], 8'h00);
            chk("R3", $sformatf("ptr after write %0d", i), ptr,
                (i == 6 || i == 7 || i == 14 || i == 15) ? i : i + 1);
        end
    endtask

    task automatic t_roundtrip;
        logic [7:0] v;
        wr_at(0, 8'h9E);
        chk("R4", "sub_out", sub_out, 8'h9E);
        wr_at(2, 8'h34); wr(8'h12); wr(8'hCD); wr(8'hAB);
        chk("R4", "data_addr", data_addr, 16'hABCD);
        wr_at(8, 8'h11); wr(8'h22); wr(8'h00); wr(8'h5A); wr(8'h77); wr(8'h66); wr(8'hC3);
        chk("R4", "ctrl_out", ctrl_out, 24'hC35A00);
        chk("R4", "ptr after ctl2", ptr, 14);
        rd_at(2, v); chk("R4", "cnt lo", v, 8'h34);
        rd(v);       chk("R4", "cnt hi", v, 8'h12);
        rd_at(8, v); chk("R4", "blk lo", v, 8'h77);
        rd(v);       chk("R4", "blk hi", v, 8'h66);
        rd(v);       chk("R4", "wa lo", v, 8'h11);
        rd(v);       chk("R4", "wa hi", v, 8'h22);
    endtask

    task automatic t_transfer;
        logic [7:0] v;
        wr_at(1, 8'h00);
        wr_at(6, 8'h00);
        chk("R6", "no busy when disabled", busy, 0);
        chk("R6", "no pulse when disabled", xfer_start, 0);
        rd_at(1, v); chk("R6", "ifst unchanged", v, 8'hFF);
        wr_at(1, 8'h02);
        wr_at(6, 8'h00);
        chk("R6", "pulse", xfer_start, 1);
        chk("R6", "busy", busy, 1);
        chk("R6", "ptr holds", ptr, 6);
        @(negedge clk);
        chk("R6", "pulse one cycle", xfer_start, 0);
        rd_at(1, v); chk("R6", "ifst bit3 clear", v, 8'hF7);
        wr_at(2, 8'h34); wr(8'h12);
        wr_at(1, 8'h00);
        chk("R5", "busy cleared", busy, 0);
        chk("R5", "if_ctrl", if_ctrl, 8'h00);
        rd_at(1, v); chk("R5", "ifst bit3 set", v, 8'hFF);
        rd_at(2, v); chk("R5", "cnt lo zero", v, 8'h00);
        rd(v);       chk("R5", "cnt hi zero", v, 8'h00);
    endtask

    task automatic t_ack;
        logic [7:0] v;
        pulse_evt(1'b1);
        rd_at(1, v); chk("R7", "end flag low", v, 8'hBF);
        wr_at(7, 8'h00);
        chk("R7", "ptr holds", ptr, 7);
        rd_at(1, v); chk("R7", "ack sets bit6", v, 8'hFF);
    endtask

    task automatic t_decode;
        logic [7:0] v;
        wr_at(15, 8'h00);
        pulse_evt(1'b0);
        rd_at(1, v); chk("R8", "dec flag low", v, 8'hDF);
        wr_at(10, 8'h80);
        wr_at(1, 8'h20);
        rd_at(4, v); rd(v); rd(v); rd(v); rd(v); rd(v);
        rd_at(12, v); rd(v);
        rd_at(15, v); chk("R8", "st3 first read", v, 8'h00);
        rd(v);        chk("R8", "st3 not ready, reg14 unread", v, 8'h00);
        rd_at(1, v);  chk("R8", "read 15 sets bit5", v, 8'hFF);
        rd_at(14, v);
        rd(v);        chk("R8", "st3 returns old value", v, 8'h00);
        rd(v);        chk("R8", "st3 ready", v, 8'h80);
        // enables incomplete: if_ctrl bit5 clear after soft reset
        wr_at(15, 8'h00);
        wr_at(10, 8'h80);
        rd_at(1, v); rd_at(4, v); rd(v); rd(v); rd(v); rd(v); rd(v);
        rd_at(12, v); rd(v); rd(v);
        rd(v); rd(v); chk("R8", "st3 without if_ctrl bit5", v, 8'h00);
    endtask

    task automatic t_softrst;
        logic [7:0] v;
        wr_at(2, 8'h34); wr(8'h12); wr(8'hCD); wr(8'hAB);
        wr_at(8, 8'h99);
        wr_at(1, 8'h02); wr_at(6, 8'h00);
        wr_at(10, 8'h80); wr_at(0, 8'h9E);
        chk("R9", "busy before", busy, 1);
        wr_at(15, 8'h00);
        chk("R9", "ptr stays 15", ptr, 15);
        chk("R9", "busy", busy, 0);
        chk("R9", "outputs", {if_ctrl, sub_out, data_addr, ctrl_out}, 0);
        rd_at(2, v); chk("R9", "cnt lo", v, 8'h00);
        rd(v);       chk("R9", "cnt hi", v, 8'h00);
        rd_at(10, v); chk("R9", "wa lo", v, 8'h60);
        rd(v);        chk("R9", "wa hi", v, 8'h12);
        rd(v);        chk("R9", "st0", v, 8'h80);
        rd_at(1, v);  chk("R9", "ifst", v, 8'hFF);
        rd_at(7, v);  chk("R9", "hdr3", v, 8'h01);
    endtask

    task automatic t_ptrload;
        wr_at(3, 8'h5C);
        set_ptr(3);
        @(negedge clk); ptr_we = 1'b1; ptr_wdata = 4'd9; rd_stb = 1'b1;
        @(negedge clk); ptr_we = 1'b0; rd_stb = 1'b0;
        chk("R10", "load wins", ptr, 9);
        chk("R10", "read used old ptr", rdata, 8'h5C);
    endtask

    task automatic t_both;
        logic [7:0] v;
        logic [7:0] prev;
        set_ptr(2);
        prev = rdata;
        @(negedge clk); rd_stb = 1'b1; wr_stb = 1'b1; wdata = 8'h55;
        @(negedge clk); rd_stb = 1'b0; wr_stb = 1'b0;
        chk("R11", "write advance", ptr, 3);
        chk("R11", "rdata held", rdata, prev);
        rd_at(2, v); chk("R11", "written", v, 8'h55);
    endtask

    task automatic t_cmd;
        logic [7:0] v;
        cmd_in = 8'hA7;
        rd_at(0, v);
        chk("R12", "cmd", v, 8'hA7);
        chk("R12", "ptr", ptr, 1);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(5.0 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; ptr_we = 0; rd_stb = 0; wr_stb = 0; end_evt = 0; dec_evt = 0;
        ptr_wdata = 0; wdata = 0; cmd_in = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_wr_ptr();
        t_roundtrip();
        t_transfer();
        t_ack();
        t_decode();
        t_softrst();
        t_ptrload();
        t_both();
        t_cmd();
        summary();
        $finish;
    end

endmodule